// File: doc/BRIEF.md
# Emulation and Power-Sequence Interrupt Aggregator

This block watches a group of power domains and the modules inside them for two kinds of event. The first kind is a debug override that conflicts with what software asked for: a sleep inhibit, a forced-active request or a local-reset override. The second is a power sequencer that is waiting for an external supply to be switched. Each event is latched into a pending bit, qualified by its own enable bit and merged into a single interrupt line to the CPU's interrupt controller.

Software reads one summary word per group (modules in two 32-bit words, domains in one, external-power in one). It then reads the status word of the flagged module or domain to learn the cause, and clears the summary bit with a write-one-to-clear. Before leaving its handler, software writes a re-evaluate command. This raises the interrupt again if anything enabled is still pending, so no event is lost while interrupts were masked.

Every event condition is edge-detected. An event is a cycle in which its condition becomes true after being false in the previous cycle. The interrupt line is a single-cycle pulse driven from a two-state machine: `IRQ_QUIET` is the idle state and `IRQ_FIRE` drives the pulse. The transition QUIET→FIRE is taken on a trigger. FIRE→FIRE is taken when another trigger arrives in the pulse cycle. FIRE→QUIET is taken otherwise.

Top module: `pwr_emu_irq_hub`

## Requirements
- R1: A module inhibit-sleep event is raised when `dbg_inhibit[m]` is high, `mod_is_en[m]` is high, `sw_req_vld[m]` is high and `sw_req_en[m]` is low.
- R2: A module inhibit-sleep event is also raised when `dbg_force[m]` is high while `mod_is_en[m]` is low.
- R3: A module reset-override event is raised in any of three cases:
  - `dbg_assert_rst[m]` and `sw_lrst_rel[m]` are both high;
  - `dbg_wait_rst[m]` is high;
  - `dbg_block_rst[m]` and `sw_lrst_wr[m]` are both high.
- R4: A domain inhibit event is raised when `pd_dbg_inhibit[d]`, `pd_is_on[d]` and `pd_off_req[d]` are all high. An external-power event is raised for domain d in the cycle where `pd_pwr_wait[d]` rises.
- R5: Any event condition latches only on its rising edge, and only if its enable bit is set. The enable bits are:
  - bit 0 of the module word (0x40+m) for inhibit-sleep;
  - bit 1 of the module word for reset-override;
  - bit 0 of the domain word (0x20+d) for domain inhibit;
  - bit d of 0x05 for external power.
  All enables reset to 0.
- R6: Module m's summary bit is at address 0x00 bit m for m<32, and at 0x01 bit m-32 otherwise. Domain summaries are at 0x02 bit d, and external-power pending is at 0x03 bit d. In the module word, bit 8 is the inhibit cause and bit 9 is the reset cause. In the domain word, bit 8 is the inhibit cause.
- R7: Writing 1 to a bit of 0x00–0x03 clears that pending bit, together with the cause bits of that module or domain. Writing 0 leaves it unchanged.
- R8: An event in the same cycle as a clear of the same bit wins, and the bit stays set.
- R9: `irq` is high for exactly the cycle after each cycle in which an enabled event latches.
- R10: Writing 1 to bit 0 of 0x04 pulses `irq` in the next cycle when any enabled pending bit is set. An enabled pending bit is one of:
  - a module cause with its enable set;
  - a domain cause with its enable set;
  - an external-power bit with its enable set.
  The re-evaluate write has no effect otherwise, and 0x04 reads 0.
- R11: After reset, all pending, cause and enable bits and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_inhibit | input | NUM_MOD | Debug sleep-inhibit per module |
| dbg_force | input | NUM_MOD | Debug force-active per module |
| dbg_assert_rst | input | NUM_MOD | Debug hold-in-reset per module |
| dbg_wait_rst | input | NUM_MOD | Debug wait-in-reset per module |
| dbg_block_rst | input | NUM_MOD | Debug freeze of local reset per module |
| mod_is_en | input | NUM_MOD | Module currently in enabled state |
| sw_req_vld | input | NUM_MOD | Software state-change request strobe |
| sw_req_en | input | NUM_MOD | Requested target is the enabled state |
| sw_lrst_rel | input | NUM_MOD | Software has released local reset |
| sw_lrst_wr | input | NUM_MOD | Software writes local reset this cycle |
| pd_dbg_inhibit | input | NUM_DOM | Debug sleep-inhibit per domain |
| pd_is_on | input | NUM_DOM | Domain is powered |
| pd_off_req | input | NUM_DOM | Software requests domain power-off |
| pd_pwr_wait | input | NUM_DOM | Sequencer waits for supply confirmation |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench builds the block with 36 modules and 3 domains. With 36 modules, indices fall on both sides of the 32-bit boundary, so the upper summary word and its partial width are exercised. With 3 domains, the domain and external-power fields are only partly filled. The bench runs a behavioural model alongside the design and compares `irq` every cycle. It applies each event source with its enable both off and on, applies clears with the event arriving in the same cycle, and issues re-evaluate commands with and without pending work.

// File: rtl/pe_pkg.sv
package pe_pkg;
    typedef enum logic [0:0] {IRQ_QUIET, IRQ_FIRE} irq_state_t;

    localparam logic [7:0] A_MPEND_LO = 8'h00;
    localparam logic [7:0] A_MPEND_HI = 8'h01;
    localparam logic [7:0] A_DPEND    = 8'h02;
    localparam logic [7:0] A_XPEND    = 8'h03;
    localparam logic [7:0] A_REEVAL   = 8'h04;
    localparam logic [7:0] A_XEN      = 8'h05;
endpackage

// File: rtl/pe_mod_events.sv
module pe_mod_events #(
    parameter int NUM_MOD = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MOD-1:0] dbg_inhibit,
    input  logic [NUM_MOD-1:0] dbg_force,
    input  logic [NUM_MOD-1:0] dbg_assert_rst,
    input  logic [NUM_MOD-1:0] dbg_wait_rst,
    input  logic [NUM_MOD-1:0] dbg_block_rst,
    input  logic [NUM_MOD-1:0] mod_is_en,
    input  logic [NUM_MOD-1:0] sw_req_vld,
    input  logic [NUM_MOD-1:0] sw_req_en,
    input  logic [NUM_MOD-1:0] sw_lrst_rel,
    input  logic [NUM_MOD-1:0] sw_lrst_wr,
    input  logic [NUM_MOD-1:0] en_inh,
    input  logic [NUM_MOD-1:0] en_rst,
    input  logic [NUM_MOD-1:0] clr,
    output logic [NUM_MOD-1:0] pend,
    output logic [NUM_MOD-1:0] cause_inh,
    output logic [NUM_MOD-1:0] cause_rst,
    output logic [NUM_MOD-1:0] mod_set
);
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        logic cond_inh, cond_rst, prev_inh, prev_rst, new_inh, new_rst;

        assign cond_inh = (dbg_inhibit[m] & mod_is_en[m] & sw_req_vld[m] & ~sw_req_en[m])
                        | (dbg_force[m] & ~mod_is_en[m]);
        assign cond_rst = (dbg_assert_rst[m] & sw_lrst_rel[m])
                        | dbg_wait_rst[m]
                        | (dbg_block_rst[m] & sw_lrst_wr[m]);
        assign new_inh  = cond_inh & ~prev_inh & en_inh[m];
        assign new_rst  = cond_rst & ~prev_rst & en_rst[m];
        assign mod_set[m] = new_inh | new_rst;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_inh     <= 1'b0;
                prev_rst     <= 1'b0;
                pend[m]      <= 1'b0;
                cause_inh[m] <= 1'b0;
                cause_rst[m] <= 1'b0;
            end else begin
                prev_inh <= cond_inh;
                prev_rst <= cond_rst;
                if (new_inh | new_rst) pend[m] <= 1'b1;
                else if (clr[m])       pend[m] <= 1'b0;
                if (new_inh)           cause_inh[m] <= 1'b1;
                else if (clr[m])       cause_inh[m] <= 1'b0;
                if (new_rst)           cause_rst[m] <= 1'b1;
                else if (clr[m])       cause_rst[m] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pe_dom_events.sv
module pe_dom_events #(
    parameter int NUM_DOM = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] pd_dbg_inhibit,
    input  logic [NUM_DOM-1:0] pd_is_on,
    input  logic [NUM_DOM-1:0] pd_off_req,
    input  logic [NUM_DOM-1:0] pd_pwr_wait,
    input  logic [NUM_DOM-1:0] en_inh,
    input  logic [NUM_DOM-1:0] en_xp,
    input  logic [NUM_DOM-1:0] clr_dom,
    input  logic [NUM_DOM-1:0] clr_xp,
    output logic [NUM_DOM-1:0] pend_dom,
    output logic [NUM_DOM-1:0] pend_xp,
    output logic [NUM_DOM-1:0] dom_set
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic cond_inh, prev_inh, prev_wait, new_inh, new_xp;

        assign cond_inh   = pd_dbg_inhibit[d] & pd_is_on[d] & pd_off_req[d];
        assign new_inh    = cond_inh & ~prev_inh & en_inh[d];
        assign new_xp     = pd_pwr_wait[d] & ~prev_wait & en_xp[d];
        assign dom_set[d] = new_inh | new_xp;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_inh    <= 1'b0;
                prev_wait   <= 1'b0;
                pend_dom[d] <= 1'b0;
                pend_xp[d]  <= 1'b0;
            end else begin
                prev_inh  <= cond_inh;
                prev_wait <= pd_pwr_wait[d];
                if (new_inh)         pend_dom[d] <= 1'b1;
                else if (clr_dom[d]) pend_dom[d] <= 1'b0;
                if (new_xp)          pend_xp[d]  <= 1'b1;
                else if (clr_xp[d])  pend_xp[d]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pe_irq_fsm.sv
module pe_irq_fsm
    import pe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic new_evt,
    input  logic reeval,
    input  logic any_pend,
    output logic irq
);
    irq_state_t state, state_nx;
    logic       trigger;

    assign trigger = new_evt | (reeval & any_pend);

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_QUIET: state_nx = trigger ? IRQ_FIRE : IRQ_QUIET;
            IRQ_FIRE:  state_nx = trigger ? IRQ_FIRE : IRQ_QUIET;
            default:   state_nx = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        irq = (state == IRQ_FIRE);
    end
endmodule

// File: rtl/pwr_emu_irq_hub.sv
module pwr_emu_irq_hub
    import pe_pkg::*;
#(
    parameter int NUM_MOD = 64,
    parameter int NUM_DOM = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MOD-1:0] dbg_inhibit,
    input  logic [NUM_MOD-1:0] dbg_force,
    input  logic [NUM_MOD-1:0] dbg_assert_rst,
    input  logic [NUM_MOD-1:0] dbg_wait_rst,
    input  logic [NUM_MOD-1:0] dbg_block_rst,
    input  logic [NUM_MOD-1:0] mod_is_en,
    input  logic [NUM_MOD-1:0] sw_req_vld,
    input  logic [NUM_MOD-1:0] sw_req_en,
    input  logic [NUM_MOD-1:0] sw_lrst_rel,
    input  logic [NUM_MOD-1:0] sw_lrst_wr,
    input  logic [NUM_DOM-1:0] pd_dbg_inhibit,
    input  logic [NUM_DOM-1:0] pd_is_on,
    input  logic [NUM_DOM-1:0] pd_off_req,
    input  logic [NUM_DOM-1:0] pd_pwr_wait,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);
    localparam int MOD_SPAN = 64;

    logic [NUM_MOD-1:0] en_inh, en_rst, clr_mod, pend_mod, cause_inh, cause_rst, mod_set;
    logic [NUM_DOM-1:0] en_dinh, en_xp, clr_dom, clr_xp, pend_dom, pend_xp, dom_set;
    logic [MOD_SPAN-1:0] mpend_w, mclr_w;
    logic               mod_hit, dom_hit, reeval, evt_any, any_pend;
    logic [5:0]         midx;
    logic [2:0]         didx;

    assign midx    = reg_addr[5:0];
    assign didx    = reg_addr[2:0];
    assign mod_hit = (reg_addr[7:6] == 2'b01) && (32'(midx) < NUM_MOD);
    assign dom_hit = (reg_addr[7:3] == 5'b00100) && (32'(didx) < NUM_DOM);
    assign reeval  = reg_wr && (reg_addr == A_REEVAL) && reg_wdata[0];

    always_comb begin
        mclr_w = '0;
        if (reg_wr && reg_addr == A_MPEND_LO) mclr_w[31:0]  = reg_wdata;
        if (reg_wr && reg_addr == A_MPEND_HI) mclr_w[63:32] = reg_wdata;
    end
    assign clr_mod = mclr_w[NUM_MOD-1:0];
    assign clr_dom = (reg_wr && reg_addr == A_DPEND) ? reg_wdata[NUM_DOM-1:0] : '0;
    assign clr_xp  = (reg_wr && reg_addr == A_XPEND) ? reg_wdata[NUM_DOM-1:0] : '0;

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_men
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_inh[m] <= 1'b0;
                en_rst[m] <= 1'b0;
            end else if (reg_wr && mod_hit && 32'(midx) == m) begin
                en_inh[m] <= reg_wdata[0];
                en_rst[m] <= reg_wdata[1];
            end
        end
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_den
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_dinh[d] <= 1'b0;
                en_xp[d]   <= 1'b0;
            end else begin
                if (reg_wr && dom_hit && 32'(didx) == d) en_dinh[d] <= reg_wdata[0];
                if (reg_wr && reg_addr == A_XEN)         en_xp[d]   <= reg_wdata[d];
            end
        end
    end

    pe_mod_events #(.NUM_MOD(NUM_MOD)) u_mod (
        .clk(clk), .rst_n(rst_n),
        .dbg_inhibit(dbg_inhibit), .dbg_force(dbg_force),
        .dbg_assert_rst(dbg_assert_rst), .dbg_wait_rst(dbg_wait_rst),
        .dbg_block_rst(dbg_block_rst), .mod_is_en(mod_is_en),
        .sw_req_vld(sw_req_vld), .sw_req_en(sw_req_en),
        .sw_lrst_rel(sw_lrst_rel), .sw_lrst_wr(sw_lrst_wr),
        .en_inh(en_inh), .en_rst(en_rst), .clr(clr_mod),
        .pend(pend_mod), .cause_inh(cause_inh), .cause_rst(cause_rst),
        .mod_set(mod_set)
    );

    pe_dom_events #(.NUM_DOM(NUM_DOM)) u_dom (
        .clk(clk), .rst_n(rst_n),
        .pd_dbg_inhibit(pd_dbg_inhibit), .pd_is_on(pd_is_on),
        .pd_off_req(pd_off_req), .pd_pwr_wait(pd_pwr_wait),
        .en_inh(en_dinh), .en_xp(en_xp), .clr_dom(clr_dom), .clr_xp(clr_xp),
        .pend_dom(pend_dom), .pend_xp(pend_xp), .dom_set(dom_set)
    );

    assign evt_any  = (|mod_set) | (|dom_set);
    assign any_pend = (|(cause_inh & en_inh)) | (|(cause_rst & en_rst))
                    | (|(pend_dom & en_dinh)) | (|(pend_xp & en_xp));

    pe_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .new_evt(evt_any),
        .reeval(reeval), .any_pend(any_pend), .irq(irq)
    );

    always_comb begin
        mpend_w = '0;
        mpend_w[NUM_MOD-1:0] = pend_mod;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_MPEND_LO)      reg_rdata = mpend_w[31:0];
        else if (reg_addr == A_MPEND_HI) reg_rdata = mpend_w[63:32];
        else if (reg_addr == A_DPEND)    reg_rdata[NUM_DOM-1:0] = pend_dom;
        else if (reg_addr == A_XPEND)    reg_rdata[NUM_DOM-1:0] = pend_xp;
        else if (reg_addr == A_XEN)      reg_rdata[NUM_DOM-1:0] = en_xp;
        else if (dom_hit) begin
            reg_rdata[0] = en_dinh[didx];
            reg_rdata[8] = pend_dom[didx];
        end else if (mod_hit) begin
            reg_rdata[0] = en_inh[midx];
            reg_rdata[1] = en_rst[midx];
            reg_rdata[8] = cause_inh[midx];
            reg_rdata[9] = cause_rst[midx];
        end
    end
endmodule

// File: rtl/pe_irq_chk.sv
module pe_irq_chk #(
    parameter int NUM_MOD = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq,
    input logic               reg_wr,
    input logic [7:0]         reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic               any_pend,
    input logic               evt_any,
    input logic [NUM_MOD-1:0] mod_set,
    input logic [NUM_MOD-1:0] pend_mod
);
    AST_REEVAL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h04 && reg_wdata[0] && any_pend) |=> irq); // R10

    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(evt_any || (reg_wr && reg_addr == 8'h04 && reg_wdata[0]))); // R9

    AST_EVENT_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        evt_any |=> irq); // R9

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|mod_set) |=> ((pend_mod & $past(mod_set)) == $past(mod_set))); // R8

    AST_ZERO_WRITE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h00 && reg_wdata == 32'h0 && mod_set == '0) |=> $stable(pend_mod)); // R7

    AST_REEVAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h04) |-> (reg_rdata == 32'h0)); // R10
endmodule

bind pwr_emu_irq_hub pe_irq_chk #(.NUM_MOD(NUM_MOD)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .any_pend(any_pend),
    .evt_any(evt_any), .mod_set(mod_set), .pend_mod(pend_mod)
);

// File: tb/sim_pwr_emu_irq_hub.sv
`timescale 1ns/1ps
module sim_pwr_emu_irq_hub;
    localparam int NM = 36;
    localparam int ND = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0] dbg_inhibit = '0, dbg_force = '0, dbg_assert_rst = '0, dbg_wait_rst = '0;
    logic [NM-1:0] dbg_block_rst = '0, mod_is_en = '0, sw_req_vld = '0, sw_req_en = '0;
    logic [NM-1:0] sw_lrst_rel = '0, sw_lrst_wr = '0;
    logic [ND-1:0] pd_dbg_inhibit = '0, pd_is_on = '0, pd_off_req = '0, pd_pwr_wait = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_emu_irq_hub #(.NUM_MOD(NM), .NUM_DOM(ND)) u0 (.*);

    // behavioural reference model
    bit m_pend[NM], m_ci[NM], m_cr[NM], m_qi[NM], m_qr[NM], m_ei[NM], m_er[NM];
    bit d_pend[ND], d_x[ND], d_qi[ND], d_qw[ND], d_ei[ND], d_ex[ND];
    bit irq_exp;
    bit trig, anyp, ci_now, cr_now, ni, nr, clr_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NM; i++) begin
                m_pend[i] = 0; m_ci[i] = 0; m_cr[i] = 0; m_qi[i] = 0; m_qr[i] = 0; m_ei[i] = 0; m_er[i] = 0;
            end
            for (int i = 0; i < ND; i++) begin
                d_pend[i] = 0; d_x[i] = 0; d_qi[i] = 0; d_qw[i] = 0; d_ei[i] = 0; d_ex[i] = 0;
            end
            irq_exp = 0;
        end else begin
            trig = 0; anyp = 0;
            for (int i = 0; i < NM; i++) if ((m_ci[i] && m_ei[i]) || (m_cr[i] && m_er[i])) anyp = 1;
            for (int i = 0; i < ND; i++) if ((d_pend[i] && d_ei[i]) || (d_x[i] && d_ex[i])) anyp = 1;
            for (int i = 0; i < NM; i++) begin
                ci_now = (dbg_inhibit[i] && mod_is_en[i] && sw_req_vld[i] && !sw_req_en[i]) ||
                         (dbg_force[i] && !mod_is_en[i]);
                cr_now = (dbg_assert_rst[i] && sw_lrst_rel[i]) || dbg_wait_rst[i] ||
                         (dbg_block_rst[i] && sw_lrst_wr[i]);
                ni = ci_now && !m_qi[i] && m_ei[i];
                nr = cr_now && !m_qr[i] && m_er[i];
                m_qi[i] = ci_now; m_qr[i] = cr_now;
                clr_b = reg_wr && ((i < 32) ? (reg_addr == 8'h00 && reg_wdata[i])
                                            : (reg_addr == 8'h01 && reg_wdata[i-32]));
                if (clr_b) begin m_pend[i] = 0; m_ci[i] = 0; m_cr[i] = 0; end
                if (ni) begin m_pend[i] = 1; m_ci[i] = 1; end
                if (nr) begin m_pend[i] = 1; m_cr[i] = 1; end
                if (ni || nr) trig = 1;
                if (reg_wr && reg_addr == 8'h40 + 8'(i)) begin m_ei[i] = reg_wdata[0]; m_er[i] = reg_wdata[1]; end
            end
            for (int i = 0; i < ND; i++) begin
                ci_now = pd_dbg_inhibit[i] && pd_is_on[i] && pd_off_req[i];
                ni = ci_now && !d_qi[i] && d_ei[i];
                nr = pd_pwr_wait[i] && !d_qw[i] && d_ex[i];
                d_qi[i] = ci_now; d_qw[i] = pd_pwr_wait[i];
                if (reg_wr && reg_addr == 8'h02 && reg_wdata[i]) d_pend[i] = 0;
                if (reg_wr && reg_addr == 8'h03 && reg_wdata[i]) d_x[i] = 0;
                if (ni) d_pend[i] = 1;
                if (nr) d_x[i] = 1;
                if (ni || nr) trig = 1;
                if (reg_wr && reg_addr == 8'h20 + 8'(i)) d_ei[i] = reg_wdata[0];
                if (reg_wr && reg_addr == 8'h05) d_ex[i] = reg_wdata[i];
            end
            irq_exp = trig || (reg_wr && reg_addr == 8'h04 && reg_wdata[0] && anyp);
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) begin for (int i = 0; i < 32 && i < NM; i++) r[i] = m_pend[i]; end
        else if (a == 8'h01) begin for (int i = 32; i < NM; i++) r[i-32] = m_pend[i]; end
        else if (a == 8'h02) begin for (int i = 0; i < ND; i++) r[i] = d_pend[i]; end
        else if (a == 8'h03) begin for (int i = 0; i < ND; i++) r[i] = d_x[i]; end
        else if (a == 8'h05) begin for (int i = 0; i < ND; i++) r[i] = d_ex[i]; end
        else if (a >= 8'h20 && a < 8'h20 + 8'(ND)) begin
            r[0] = d_ei[a-8'h20]; r[8] = d_pend[a-8'h20];
        end else if (a >= 8'h40 && a < 8'h40 + 8'(NM)) begin
            r[0] = m_ei[a-8'h40]; r[1] = m_er[a-8'h40]; r[8] = m_ci[a-8'h40]; r[9] = m_cr[a-8'h40];
        end
        return r;
    endfunction

    // irq compared to the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (irq !== irq_exp) begin
                n_bad++;
                $display("FAIL R9/R10 irq at %0t: actual %0b expected %0b", $time, irq, irq_exp);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, exp_rd(a));
    endtask

    task automatic rd_lit(input logic [7:0] a, input logic [31:0] v, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, v);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R11 reset state
        rd_lit(8'h00, 32'h0, "R11 mod pend lo");
        rd_lit(8'h01, 32'h0, "R11 mod pend hi");
        rd_lit(8'h03, 32'h0, "R11 xpend");
        rd_lit(8'h45, 32'h0, "R11 mod word");
        chk("R11 irq", {31'b0, irq}, 32'h0);

        // R5 disabled event latches nothing
        @(negedge clk); dbg_wait_rst[3] = 1'b1;
        idle(2);
        rd_lit(8'h00, 32'h0, "R5 disabled wait-reset");
        @(negedge clk); dbg_wait_rst[3] = 1'b0;

        wr(8'h43, 32'h2);
        wr(8'h45, 32'h1);
        wr(8'h40 + 8'd33, 32'h1);
        for (int i = 7; i <= 9; i++) wr(8'h40 + 8'(i), 32'h2);

        // R1 inhibit + request to leave enabled
        @(negedge clk); mod_is_en[5] = 1'b1; dbg_inhibit[5] = 1'b1; sw_req_vld[5] = 1'b1;
        @(negedge clk); sw_req_vld[5] = 1'b0;
        chk("R9 pulse after R1 event", {31'b0, irq}, 32'h1);
        rd_lit(8'h00, 32'h0000_0020, "R1/R6 summary bit 5");
        rd_lit(8'h45, 32'h0000_0101, "R1/R6 inhibit cause bit 8");

        // R2 force active while not enabled, upper word
        @(negedge clk); dbg_force[33] = 1'b1;
        idle(2);
        rd_lit(8'h01, 32'h0000_0002, "R2/R6 summary hi bit 1");
        rd(8'h40 + 8'd33, "R2 cause");

        // R3 three reset cases
        @(negedge clk); dbg_assert_rst[7] = 1'b1; sw_lrst_rel[7] = 1'b1;
        @(negedge clk); dbg_wait_rst[8] = 1'b1;
        @(negedge clk); dbg_block_rst[9] = 1'b1;
        @(negedge clk); sw_lrst_wr[9] = 1'b1;
        @(negedge clk); sw_lrst_wr[9] = 1'b0;
        rd_lit(8'h00, 32'h0000_03A0, "R3 all three cases");
        rd_lit(8'h48, 32'h0000_0202, "R3/R6 reset cause bit 9");
        rd(8'h43, "R3 untouched module");

        // R7 write 0 no effect, write 1 clears
        wr(8'h00, 32'h0);
        rd_lit(8'h00, 32'h0000_03A0, "R7 zero write");
        wr(8'h00, 32'h0000_0020);
        rd_lit(8'h00, 32'h0000_0380, "R7 clear bit 5");
        rd_lit(8'h45, 32'h0000_0001, "R7 cause cleared");

        // R8 event in same cycle as clear
        @(negedge clk); dbg_wait_rst[3] = 1'b1;
        reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0000_0008;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
        rd_lit(8'h00, 32'h0000_0388, "R8 event wins");

        // R5 level held: no second latch after clear
        wr(8'h00, 32'h0000_0008);
        idle(2);
        rd_lit(8'h00, 32'h0000_0380, "R5 edge only");

        // R10 re-evaluate with pending
        wr(8'h04, 32'h1);
        rd_lit(8'h04, 32'h0, "R10 reads zero");
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h04, 32'h1);
        rd(8'h01, "R10 after clear-all");

        // R4 domain inhibit and external-power
        wr(8'h21, 32'h1);
        wr(8'h05, 32'h4);
        @(negedge clk); pd_dbg_inhibit[1] = 1'b1; pd_is_on[1] = 1'b1; pd_off_req[1] = 1'b1;
        @(negedge clk); pd_pwr_wait[2] = 1'b1; pd_pwr_wait[0] = 1'b1;
        idle(2);
        rd_lit(8'h02, 32'h2, "R4 domain inhibit");
        rd_lit(8'h03, 32'h4, "R4/R5 ext power only enabled domain");
        rd_lit(8'h21, 32'h101, "R4/R6 domain cause");
        wr(8'h03, 32'h4);
        wr(8'h04, 32'h1);
        wr(8'h02, 32'h2);
        wr(8'h04, 32'h1);
        rd(8'h05, "R5 ext enable readback");
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule